// File: doc/BRIEF.md
# Paged SRAM address page selector

This block forms the full SRAM address for every data access of a small 8-bit processor whose data RAM spans several 256-byte pages. The processor supplies an 8-bit offset and an access class: direct, indexed, stack or register-space. The block adds the page bits in front of the offset. The page comes from one of three page pointers (current, stack, index) or is forced to zero. A 2-bit paging mode held in the processor flag byte makes that choice.

Direct and indexed accesses follow separate page rules. When an interrupt is taken, the flag byte is pushed onto a small shadow stack and then cleared, so a handler starts in the single-page mode. On return from interrupt, the most recently saved flag byte is restored. The page pointers are never saved or restored automatically. The shadow stack supports nested interrupts. A push onto a full stack or a pop from an empty stack sets a sticky error flag.

Top module: `sram_page_sel`

## Requirements
- R1: After reset the flag byte, all three page pointers and the error flag are zero, and the shadow stack is empty.
- R2: The paging mode is flag bits [7:6]. In mode 00, direct (class 0) and indexed (class 1) accesses both use page 0.
- R3: In mode 01, direct accesses use page 0 and indexed accesses use the stack page pointer.
- R4: In mode 10, direct accesses use the current page pointer and indexed accesses use the index page pointer.
- R5: In mode 11, direct accesses use the current page pointer and indexed accesses use the stack page pointer.
- R6: Stack accesses (class 2) always use the stack page pointer, whatever the mode.
- R7: Register-space accesses (class 3) drive sram_en low and put page 0 on the address, whatever the mode. Every other class drives sram_en high. The address is always {page, offset}, with the offset in bits [7:0].
- R8: A write with wr_en high updates, from the next cycle, the register that wr_sel selects: 0 is the flag byte, 1 the current page pointer, 2 the stack page pointer, 3 the index page pointer. A pointer takes wr_data[2:0].
- R9: On irq_enter the flag byte is pushed onto the shadow stack and cleared to zero. Any write in the same cycle is ignored.
- R10: On irq_return the most recently pushed flag byte is restored and popped, even if the handler changed the flags. Any write in the same cycle is ignored.
- R11: The page pointers keep their values across interrupt entry and return.
- R12: irq_enter with 4 entries already stored still clears the flags but stores nothing. irq_return with an empty stack leaves the flags unchanged. Both set shadow_err, which stays set until reset.
- R13: If irq_enter and irq_return are high in the same cycle, only the entry takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 flags, 1 current, 2 stack, 3 index pointer |
| wr_data | input | 8 | Write data |
| irq_enter | input | 1 | Interrupt entry pulse |
| irq_return | input | 1 | Return-from-interrupt pulse |
| acc_class | input | 2 | 0 direct, 1 indexed, 2 stack, 3 register-space |
| acc_offset | input | 8 | Offset within the page |
| sram_en | output | 1 | High when the access targets SRAM |
| sram_addr | output | 11 | {page, offset} |
| flags | output | 8 | Current flag byte |
| cur_page | output | 3 | Current page pointer |
| stk_page | output | 3 | Stack page pointer |
| idx_page | output | 3 | Index page pointer |
| shadow_err | output | 1 | Sticky shadow stack overflow or underflow |

## Verification
The three page pointers are loaded with distinct values (5, 3, 6). All four access classes are then swept under each of the four modes, so a wrong pointer choice or a swapped mode shows up as a wrong page number rather than one that matches by chance. Interrupt sequences change both the flags and a pointer inside a handler, which separates flag restore from pointer persistence. Nesting runs to one level past the depth and back, which exercises LIFO order, overflow and underflow. Collisions are also driven: simultaneous entry and return, and a write during an interrupt event. Every cycle is compared against a queue-based model.

// File: rtl/sram_page_pkg.sv
package sram_page_pkg;
    typedef enum logic [1:0] {
        ACC_DIRECT  = 2'd0,
        ACC_INDEXED = 2'd1,
        ACC_STACK   = 2'd2,
        ACC_REGSP   = 2'd3
    } acc_class_e;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_CUR   = 2'd1,
        SEL_STK   = 2'd2,
        SEL_IDX   = 2'd3
    } wr_sel_e;

    localparam int MODE_HI = 7;
    localparam int MODE_LO = 6;
endpackage

// File: rtl/page_ptr_regs.sv
module page_ptr_regs
    import sram_page_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic              hold,
    output logic [PAGE_W-1:0] cur_q,
    output logic [PAGE_W-1:0] stk_q,
    output logic [PAGE_W-1:0] idx_q
);
    typedef struct packed {
        logic [PAGE_W-1:0] cur;
        logic [PAGE_W-1:0] stk;
        logic [PAGE_W-1:0] idx;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !hold) begin
            case (wr_sel_e'(wr_sel))
                SEL_CUR: st_d.cur = wr_page;
                SEL_STK: st_d.stk = wr_page;
                SEL_IDX: st_d.idx = wr_page;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_q = st_q.cur;
    assign stk_q = st_q.stk;
    assign idx_q = st_q.idx;

    AST_PTR_HOLD_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(cur_q) && $stable(stk_q) && $stable(idx_q))); // R11
endmodule

// File: rtl/flag_shadow.sv
module flag_shadow #(
    parameter int FLAG_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_flags,
    input  logic [FLAG_W-1:0] wr_data,
    input  logic              irq_enter,
    input  logic              irq_return,
    output logic [FLAG_W-1:0] flags_q,
    output logic              err_q
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [FLAG_W-1:0]             flags;
        logic [DEPTH-1:0][FLAG_W-1:0]  stack;
        logic [CNT_W-1:0]              count;
        logic                          err;
    } shadow_t;

    shadow_t st_d, st_q;
    logic [FLAG_W-1:0] top_w;

    always_comb begin
        top_w = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.count == CNT_W'(i + 1)) top_w = st_q.stack[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (irq_enter) begin
            if (st_q.count < CNT_W'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (st_q.count == CNT_W'(i)) st_d.stack[i] = st_q.flags;
                end
                st_d.count = st_q.count + 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
            st_d.flags = '0;
        end else if (irq_return) begin
            if (st_q.count != '0) begin
                st_d.flags = top_w;
                st_d.count = st_q.count - 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (wr_flags) begin
            st_d.flags = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign err_q   = st_q.err;

    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> (flags_q == '0)); // R9

    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter && st_q.count != '0) |=> (flags_q == $past(top_w))); // R10

    AST_UNDERFLOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter && st_q.count == '0) |=> ($stable(flags_q) && err_q)); // R12

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R12

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH)); // R12
endmodule

// File: rtl/page_mux.sv
module page_mux
    import sram_page_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int OFS_W  = 8
) (
    input  logic [1:0]              mode,
    input  logic [1:0]              acc_class,
    input  logic [OFS_W-1:0]        offset,
    input  logic [PAGE_W-1:0]       cur,
    input  logic [PAGE_W-1:0]       stk,
    input  logic [PAGE_W-1:0]       idx,
    output logic                    sram_en,
    output logic [PAGE_W+OFS_W-1:0] addr
);
    logic [PAGE_W-1:0] direct_pg, indexed_pg, page;

    always_comb begin
        direct_pg = mode[1] ? cur : '0;
        case (mode)
            2'b00:   indexed_pg = '0;
            2'b10:   indexed_pg = idx;
            default: indexed_pg = stk;
        endcase
        sram_en = 1'b1;
        case (acc_class_e'(acc_class))
            ACC_DIRECT:  page = direct_pg;
            ACC_INDEXED: page = indexed_pg;
            ACC_STACK:   page = stk;
            default: begin
                page    = '0;
                sram_en = 1'b0;
            end
        endcase
        addr = {page, offset};
    end
endmodule

// File: rtl/sram_page_sel.sv
module sram_page_sel
    import sram_page_pkg::*;
#(
    parameter int PAGE_W = 3,
    parameter int OFS_W  = 8,
    parameter int FLAG_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [FLAG_W-1:0]       wr_data,
    input  logic                    irq_enter,
    input  logic                    irq_return,
    input  logic [1:0]              acc_class,
    input  logic [OFS_W-1:0]        acc_offset,
    output logic                    sram_en,
    output logic [PAGE_W+OFS_W-1:0] sram_addr,
    output logic [FLAG_W-1:0]       flags,
    output logic [PAGE_W-1:0]       cur_page,
    output logic [PAGE_W-1:0]       stk_page,
    output logic [PAGE_W-1:0]       idx_page,
    output logic                    shadow_err
);
    localparam int ADDR_W = PAGE_W + OFS_W;

    logic irq_event;
    logic wr_flags;

    assign irq_event = irq_enter || irq_return;
    assign wr_flags  = wr_en && (wr_sel_e'(wr_sel) == SEL_FLAGS);

    page_ptr_regs #(.PAGE_W(PAGE_W)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_page (wr_data[PAGE_W-1:0]),
        .hold    (irq_event),
        .cur_q   (cur_page),
        .stk_q   (stk_page),
        .idx_q   (idx_page)
    );

    flag_shadow #(.FLAG_W(FLAG_W), .DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_flags   (wr_flags),
        .wr_data    (wr_data),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .flags_q    (flags),
        .err_q      (shadow_err)
    );

    page_mux #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_mux (
        .mode      (flags[MODE_HI:MODE_LO]),
        .acc_class (acc_class),
        .offset    (acc_offset),
        .cur       (cur_page),
        .stk       (stk_page),
        .idx       (idx_page),
        .sram_en   (sram_en),
        .addr      (sram_addr)
    );

    AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == 2'd2) |-> (sram_addr[ADDR_W-1:OFS_W] == stk_page)); // R6

    AST_REGSP_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == 2'd3) |-> (!sram_en && sram_addr[ADDR_W-1:OFS_W] == '0)); // R7

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        sram_addr[OFS_W-1:0] == acc_offset); // R7
endmodule

// File: tb/sram_page_sel_test.sv
`timescale 1ns/1ps
module sram_page_sel_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic irq_enter = 1'b0;
    logic irq_return = 1'b0;
    logic [1:0] acc_class = 2'd0;
    logic [7:0] acc_offset = 8'd0;
    logic sram_en;
    logic [10:0] sram_addr;
    logic [7:0] flags;
    logic [2:0] cur_page, stk_page, idx_page;
    logic shadow_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_flags, m_cur, m_stk, m_idx, m_err;
    int m_q[$];

    always #4 clk = ~clk;

    sram_page_sel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_enter(irq_enter), .irq_return(irq_return), .acc_class(acc_class),
        .acc_offset(acc_offset), .sram_en(sram_en), .sram_addr(sram_addr), .flags(flags),
        .cur_page(cur_page), .stk_page(stk_page), .idx_page(idx_page), .shadow_err(shadow_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_page(input int cls);
        int mode = (m_flags >> 6) & 3;
        case (cls)
            0: return (mode >= 2) ? m_cur : 0;
            1: return (mode == 0) ? 0 : (mode == 2) ? m_idx : m_stk;
            2: return m_stk;
            default: return 0;
        endcase
    endfunction

    task automatic compare(input string tag);
        int pg = exp_page(acc_class);
        chk(tag, "sram_addr", sram_addr, pg * 256 + acc_offset);
        chk(tag, "sram_en", sram_en, (acc_class == 2'd3) ? 0 : 1);
        chk(tag, "flags", flags, m_flags);
        chk(tag, "cur_page", cur_page, m_cur);
        chk(tag, "stk_page", stk_page, m_stk);
        chk(tag, "idx_page", idx_page, m_idx);
        chk(tag, "shadow_err", shadow_err, m_err);
    endtask

    task automatic model_update();
        if (irq_enter) begin
            if (m_q.size() < 4) m_q.push_back(m_flags);
            else m_err = 1;
            m_flags = 0;
        end else if (irq_return) begin
            if (m_q.size() > 0) m_flags = m_q.pop_back();
            else m_err = 1;
        end else if (wr_en) begin
            case (wr_sel)
                2'd0: m_flags = wr_data;
                2'd1: m_cur = wr_data & 7;
                2'd2: m_stk = wr_data & 7;
                default: m_idx = wr_data & 7;
            endcase
        end
    endtask

    task automatic step(input bit we, input int sel, input int d, input bit ie, input bit ir,
                        input int cls, input int ofs, input string tag);
        wr_en = we; wr_sel = 2'(sel); wr_data = 8'(d);
        irq_enter = ie; irq_return = ir;
        acc_class = 2'(cls); acc_offset = 8'(ofs);
        #1;
        compare(tag);
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(input int cls, input int ofs, input string tag);
        step(0, 0, 0, 0, 0, cls, ofs, tag);
    endtask

    task automatic do_reset();
        rst_n = 0;
        wr_en = 0; irq_enter = 0; irq_return = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_flags = 0; m_cur = 0; m_stk = 0; m_idx = 0; m_err = 0;
        m_q.delete();
    endtask

    task automatic sweep(input string tag);
        for (int c = 0; c < 4; c++) idle(c, 8'h10 + c * 37, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        sweep("R1");

        // R8 pointer writes
        step(1, 1, 8'hFD, 0, 0, 0, 1, "R8");
        step(1, 2, 3, 0, 0, 0, 2, "R8");
        step(1, 3, 6, 0, 0, 1, 3, "R8");
        sweep("R2");
        step(1, 0, 8'h40, 0, 0, 0, 0, "R8");
        sweep("R3");
        step(1, 0, 8'h85, 0, 0, 0, 0, "R8");
        sweep("R4");
        step(1, 0, 8'hC2, 0, 0, 0, 0, "R8");
        sweep("R5");
        for (int m = 0; m < 4; m++) begin
            step(1, 0, m * 64 + 1, 0, 0, 2, 8'hEE, "R6");
            idle(2, 8'h77, "R6");
            idle(3, 8'h99, "R7");
        end

        // R9 entry clears flags, write in same cycle ignored
        step(1, 0, 8'h81, 0, 0, 0, 0, "R9");
        step(1, 1, 2, 1, 0, 0, 5, "R9");
        sweep("R9");
        // change mode and a pointer inside handler
        step(1, 0, 8'hC0, 0, 0, 1, 4, "R10");
        step(1, 2, 7, 0, 0, 1, 4, "R11");
        sweep("R10");
        step(1, 3, 1, 0, 1, 1, 8, "R10");
        sweep("R10");
        idle(2, 8'h33, "R11");

        // R12 nesting to overflow
        for (int n = 0; n < 5; n++) begin
            step(1, 0, 8'h40 + n * 64 + n, 0, 0, 1, n, "R12");
            step(0, 0, 0, 1, 0, 1, n, "R12");
        end
        idle(0, 0, "R12");
        for (int n = 0; n < 5; n++) begin
            step(0, 0, 0, 0, 1, 1, n, "R10");
            idle(0, 8'h44, "R10");
        end
        idle(1, 8'h55, "R12");

        // R12 underflow alone after reset
        do_reset();
        step(1, 0, 8'h80, 0, 0, 0, 0, "R12");
        step(0, 0, 0, 0, 1, 0, 0, "R12");
        idle(0, 8'h12, "R12");
        idle(0, 8'h12, "R12");

        // R13 simultaneous entry and return
        do_reset();
        step(1, 1, 4, 0, 0, 0, 0, "R13");
        step(1, 0, 8'hC0, 0, 0, 0, 0, "R13");
        step(0, 0, 0, 1, 1, 0, 9, "R13");
        idle(0, 9, "R13");
        step(0, 0, 0, 0, 1, 0, 9, "R13");
        idle(0, 9, "R13");
        idle(1, 9, "R13");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule